// File: doc/BRIEF.md
# Always-On Shutdown and Wake-Up Controller

This block sits in the always-on part of a chip and runs from the 32768 Hz slow clock. It owns a single supply-enable output that gates the main power domain. Software turns the main supply off by writing a keyed command word. From then on the controller watches its wake sources. These are up to sixteen wake-up pins, each with its own enable, polarity and a shared debounce time, plus two alarm inputs that come from a real-time clock and a real-time timer. The first enabled event that qualifies turns the supply back on.

A status register records which sources brought the supply back. The flags stay set until software reads that register, and the read clears them. Writing zero to the mode and pin-configuration registers switches off every wake source. All inputs are expected to be synchronous to the slow clock.

Top module: `shdn_ctrl`

## Requirements
- R1: After reset, supply_en is 1 and the mode, pin-configuration and status registers all read as zero.
- R2: A write to the command register at offset 0x0 with bit 0 set and bits 31:24 equal to 0xA5 drives supply_en low at the next clock edge. A command that arrives while the supply is already off does nothing.
- R3: A write to the command register with a key other than 0xA5, or with bit 0 clear, leaves supply_en unchanged.
- R4: The debounce selector sits in bits 26:24 of the mode register at offset 0x4. Codes 0 to 5 select 0, 3, 32, 512, 4096 and 32768 cycles, and codes 6 and 7 behave like code 5. With a selection of N greater than 0, a pin that is active at N consecutive clock edges raises supply_en at the following edge. With code 0, supply_en rises at the first edge at which the pin is active. A pin that goes inactive before reaching N cycles starts counting again from zero.
- R5: In the pin-configuration register at offset 0xC, bit i enables pin i. Bit 16+i set makes pin i active-high, and bit 16+i clear makes it active-low.
- R6: A pin with its enable bit clear, an alarm whose enable bit in the mode register is clear, and every source once both registers have been written with zero, leave supply_en low.
- R7: While the supply is off, a high rtc_alarm wakes the supply when mode bit 17 is set, and a high rtt_alarm wakes it when mode bit 16 is set. Either wake takes effect at the next edge.
- R8: The status register at offset 0x8 sets bit 16+i for a wake by pin i, bit 5 for an RTC wake and bit 4 for an RTT wake. The flags are sticky. A read returns the current value and clears the flags at that edge. A flag set at the same edge as the clearing read survives.
- R9: While supply_en is 1, wake events are ignored: the supply stays on and the status register does not change.
- R10: The mode and pin-configuration registers read back the bits that were written to their defined fields. Undefined fields read as zero, and the command register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wake_pin | input | NUM_PINS | Wake-up pin levels |
| rtc_alarm | input | 1 | Real-time clock alarm |
| rtt_alarm | input | 1 | Real-time timer alarm |
| supply_en | output | 1 | Main supply enable |

## Verification
A status read, which clears the flags, can fall in the same cycle as a wake, which sets them. The bench provokes this case directly. First it leaves the RTC flag set from an earlier wake. It then turns the supply off and, on the same clock edge, both reads the status register and raises rtt_alarm. The read must return the old RTC flag, and the next read must show only the RTT flag. The RTC flag must therefore be cleared, and the new RTT flag must not be lost to the clear.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int MAX_PINS  = 16;
    localparam int DBC_CNT_W = 16;
    localparam int SEL_W     = 3;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MODE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_PINS = 4'hC;

    localparam logic [7:0] CMD_KEY = 8'hA5;

    typedef struct packed {
        logic [SEL_W-1:0] dbc_sel;
        logic             rtc_en;
        logic             rtt_en;
    } mode_t;

    typedef struct packed {
        logic [MAX_PINS-1:0] pol_high;
        logic [MAX_PINS-1:0] en;
    } pincfg_t;

    typedef struct packed {
        logic [MAX_PINS-1:0] pin;
        logic                rtc;
        logic                rtt;
    } wake_src_t;

    function automatic logic [DBC_CNT_W-1:0] dbc_limit(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 16'd0;
            3'd1:    return 16'd3;
            3'd2:    return 16'd32;
            3'd3:    return 16'd512;
            3'd4:    return 16'd4096;
            default: return 16'd32768;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input wake_src_t s);
        return {s.pin, 10'd0, s.rtc, s.rtt, 4'd0};
    endfunction
endpackage

// File: rtl/shdn_regbus.sv
module shdn_regbus
    import shdn_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  wake_src_t         status,
    output mode_t             mode,
    output pincfg_t           pincfg,
    output logic              cmd_off,
    output logic              stat_rd
);
    localparam logic [MAX_PINS-1:0] PIN_MASK = MAX_PINS'((32'd1 << NUM_PINS) - 1);

    logic wr_cmd, wr_mode, wr_pins;

    assign wr_cmd  = bus_en && bus_we && (bus_addr == OFS_CMD);
    assign wr_mode = bus_en && bus_we && (bus_addr == OFS_MODE);
    assign wr_pins = bus_en && bus_we && (bus_addr == OFS_PINS);
    assign stat_rd = bus_en && !bus_we && (bus_addr == OFS_STAT);
    assign cmd_off = wr_cmd && bus_wdata[0] && (bus_wdata[31:24] == CMD_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            pincfg <= '0;
        end else begin
            if (wr_mode) begin
                mode.dbc_sel <= bus_wdata[26:24];
                mode.rtc_en  <= bus_wdata[17];
                mode.rtt_en  <= bus_wdata[16];
            end
            if (wr_pins) begin
                pincfg.pol_high <= bus_wdata[31:16] & PIN_MASK;
                pincfg.en       <= bus_wdata[15:0] & PIN_MASK;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = {5'd0, mode.dbc_sel, 6'd0, mode.rtc_en, mode.rtt_en, 16'd0};
            OFS_STAT: bus_rdata = status_word(status);
            OFS_PINS: bus_rdata = {pincfg.pol_high, pincfg.en};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/shdn_pin_filter.sv
module shdn_pin_filter
    import shdn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  logic             pol_high,
    input  logic             enable,
    input  logic [SEL_W-1:0] dbc_sel,
    output logic             hit
);
    logic                 active;
    logic [DBC_CNT_W-1:0] limit;
    logic [DBC_CNT_W-1:0] run_cnt;

    assign active = pol_high ? pin : !pin;
    assign limit  = dbc_limit(dbc_sel);

    always_ff @(posedge clk) begin
        if (rst || !active)
            run_cnt <= '0;
        else if (run_cnt != '1)
            run_cnt <= run_cnt + 1'b1;
    end

    assign hit = enable && ((limit == '0) ? active : (run_cnt >= limit));

    assert_dbc_prior_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && limit != '0) |-> $past(active));
endmodule

// File: rtl/shdn_wake_ctrl.sv
module shdn_wake_ctrl
    import shdn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_off,
    input  logic      stat_rd,
    input  wake_src_t src,
    output logic      supply_on,
    output wake_src_t status
);
    logic wake_any;

    assign wake_any = |src;

    always_ff @(posedge clk) begin
        if (rst) begin
            supply_on <= 1'b1;
            status    <= '0;
        end else begin
            if (supply_on) begin
                if (cmd_off)
                    supply_on <= 1'b0;
            end else if (wake_any) begin
                supply_on <= 1'b1;
            end
            status <= (stat_rd ? wake_src_t'('0) : status)
                    | ((!supply_on) ? src : wake_src_t'('0));
        end
    end

    assert_off_after_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (supply_on && cmd_off) |=> !supply_on);
    assert_no_spurious_wake_R6: assert property (@(posedge clk) disable iff (rst)
        (!supply_on && !wake_any) |=> !supply_on);
    assert_status_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (supply_on && !stat_rd) |=> (status == $past(status)));
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/shdn_ctrl.sv
module shdn_ctrl
    import shdn_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] wake_pin,
    input  logic                rtc_alarm,
    input  logic                rtt_alarm,
    output logic                supply_en
);
    mode_t               mode;
    pincfg_t             pincfg;
    wake_src_t           src;
    wake_src_t           status;
    logic                cmd_off;
    logic                stat_rd;
    logic [MAX_PINS-1:0] pin_hit;

    shdn_regbus #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status), .mode(mode), .pincfg(pincfg),
        .cmd_off(cmd_off), .stat_rd(stat_rd)
    );

    for (genvar i = 0; i < MAX_PINS; i++) begin : g_pin
        if (i < NUM_PINS) begin : g_used
            shdn_pin_filter u_flt (
                .clk(clk), .rst(rst),
                .pin(wake_pin[i]),
                .pol_high(pincfg.pol_high[i]),
                .enable(pincfg.en[i]),
                .dbc_sel(mode.dbc_sel),
                .hit(pin_hit[i])
            );
        end else begin : g_absent
            assign pin_hit[i] = 1'b0;
        end
    end

    assign src.pin = pin_hit;
    assign src.rtc = rtc_alarm && mode.rtc_en;
    assign src.rtt = rtt_alarm && mode.rtt_en;

    shdn_wake_ctrl u_wake (
        .clk(clk), .rst(rst),
        .cmd_off(cmd_off), .stat_rd(stat_rd), .src(src),
        .supply_on(supply_en), .status(status)
    );

    assert_bad_key_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == OFS_CMD && supply_en
         && (bus_wdata[31:24] != CMD_KEY || !bus_wdata[0])) |=> supply_en);
    assert_rtc_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (!supply_en && rtc_alarm && mode.rtc_en) |=> supply_en);
endmodule

// File: tb/shdn_ctrl_tb.sv
module shdn_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] wake_pin = '0;
    logic        rtc_alarm = 1'b0, rtt_alarm = 1'b0;
    logic        supply_en;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shdn_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm),
        .supply_en(supply_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic shut_down();
        wr(4'h0, 32'hA500_0001);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 supply", {31'd0, supply_en}, 32'd1);
        rd(4'h4, v); check("R1 mode", v, 32'd0);
        rd(4'hC, v); check("R1 pins", v, 32'd0);
        rd(4'h8, v); check("R1 status", v, 32'd0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R10 mode", v, 32'h0703_0000);
        wr(4'hC, 32'hA5A5_0F0F);
        rd(4'hC, v); check("R10 pins", v, 32'hA5A5_0F0F);
        rd(4'h0, v); check("R10 cmd", v, 32'd0);
        wr(4'h4, 32'd0); wr(4'hC, 32'd0);
    endtask

    task automatic t_bad_key();
        wr(4'h0, 32'hA400_0001);
        check("R3 wrong key", {31'd0, supply_en}, 32'd1);
        wr(4'h0, 32'hA500_0000);
        check("R3 bit0 clear", {31'd0, supply_en}, 32'd1);
    endtask

    task automatic t_shutdown_and_disabled();
        shut_down();
        check("R2 off", {31'd0, supply_en}, 32'd0);
        rtc_alarm = 1'b1; rtt_alarm = 1'b1; wake_pin = '1;
        repeat (5) @(negedge clk);
        check("R6 alarms and pins disabled", {31'd0, supply_en}, 32'd0);
        rtc_alarm = 1'b0; rtt_alarm = 1'b0; wake_pin = '0;
    endtask

    task automatic t_rtc();
        logic [31:0] v;
        wr(4'h4, 32'h0002_0000);
        check("R7 still off", {31'd0, supply_en}, 32'd0);
        rtc_alarm = 1'b1;
        @(negedge clk);
        check("R7 rtc wake", {31'd0, supply_en}, 32'd1);
        rtc_alarm = 1'b0;
        rd(4'h8, v); check("R8 rtc flag", v, 32'h0000_0020);
        rd(4'h8, v); check("R8 cleared by read", v, 32'd0);
    endtask

    task automatic t_ignore_when_on();
        logic [31:0] v;
        rtc_alarm = 1'b1;
        repeat (4) @(negedge clk);
        rtc_alarm = 1'b0;
        check("R9 supply on", {31'd0, supply_en}, 32'd1);
        rd(4'h8, v); check("R9 status unchanged", v, 32'd0);
    endtask

    task automatic t_rtt();
        logic [31:0] v;
        wr(4'h4, 32'h0001_0000);
        shut_down();
        rtc_alarm = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 rtc without enable", {31'd0, supply_en}, 32'd0);
        rtc_alarm = 1'b0; rtt_alarm = 1'b1;
        @(negedge clk);
        check("R7 rtt wake", {31'd0, supply_en}, 32'd1);
        rtt_alarm = 1'b0;
        rd(4'h8, v); check("R8 rtt flag", v, 32'h0000_0010);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(4'h4, 32'h0003_0000);
        shut_down();
        rtc_alarm = 1'b1; @(negedge clk); rtc_alarm = 1'b0;
        shut_down();
        check("R2 off again", {31'd0, supply_en}, 32'd0);
        rtt_alarm = 1'b1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 4'h8;
        #1 v = bus_rdata;
        check("R8 read returns old flag", v, 32'h0000_0020);
        @(negedge clk);
        bus_en = 1'b0; rtt_alarm = 1'b0;
        check("R7 rtt wake in collision", {31'd0, supply_en}, 32'd1);
        rd(4'h8, v); check("R8 set wins over clear", v, 32'h0000_0010);
        rd(4'h8, v); check("R8 empty", v, 32'd0);
        wr(4'h4, 32'd0);
    endtask

    task automatic dbc_run(input logic [2:0] code, input int n, input string tag);
        logic [31:0] v;
        wr(4'hC, 32'h0001_0001);
        wr(4'h4, {5'd0, code, 24'd0});
        shut_down();
        wake_pin[0] = 1'b1;
        if (n > 0) begin
            repeat (n) @(negedge clk);
            check({tag, " not yet"}, {31'd0, supply_en}, 32'd0);
        end
        @(negedge clk);
        check({tag, " woke"}, {31'd0, supply_en}, 32'd1);
        wake_pin[0] = 1'b0;
        rd(4'h8, v); check({tag, " pin flag R8"}, v, 32'h0001_0000);
    endtask

    task automatic t_glitch_and_active_low();
        logic [31:0] v;
        wr(4'hC, 32'h0001_0001);
        wr(4'h4, 32'h0100_0000);
        shut_down();
        wake_pin[0] = 1'b1; repeat (2) @(negedge clk); wake_pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 short pulse rejected", {31'd0, supply_en}, 32'd0);
        wake_pin[3] = 1'b1;
        wr(4'hC, 32'h0000_0008);
        wr(4'h4, 32'd0);
        repeat (2) @(negedge clk);
        check("R5 active-low idle high", {31'd0, supply_en}, 32'd0);
        wake_pin[3] = 1'b0;
        @(negedge clk);
        check("R5 active-low wake", {31'd0, supply_en}, 32'd1);
        wake_pin[3] = 1'b1;
        rd(4'h8, v); check("R8 pin3 flag", v, 32'h0008_0000);
    endtask

    task automatic t_all_disabled();
        wr(4'h4, 32'd0); wr(4'hC, 32'd0);
        shut_down();
        wake_pin = '1; rtc_alarm = 1'b1; rtt_alarm = 1'b1;
        repeat (40) @(negedge clk);
        check("R6 zeroed registers", {31'd0, supply_en}, 32'd0);
        wake_pin = '0; rtc_alarm = 1'b0; rtt_alarm = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_bad_key();
        t_shutdown_and_disabled();
        t_rtc();
        t_ignore_when_on();
        t_rtt();
        t_collision();
        dbc_run(3'd0, 0, "R4 code0");
        dbc_run(3'd1, 3, "R4 code1");
        dbc_run(3'd2, 32, "R4 code2");
        dbc_run(3'd3, 512, "R4 code3");
        dbc_run(3'd5, 32768, "R4 code5");
        dbc_run(3'd7, 32768, "R4 code7");
        t_glitch_and_active_low();
        t_all_disabled();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule